// File: doc/BRIEF.md
# Radio SPI Register Access Engine

This block is an SPI master for single-byte register accesses on a radio transceiver. The transceiver has two register spaces: a short space addressed by 6 bits and a long space addressed by 10 bits. A requester gives one access: the direction, the space, the address and, for a write, the data byte. The engine then frames a complete SPI transaction. It encodes a one-byte header for the short space or a two-byte header for the long space, and then either sends the data byte or clocks a dummy byte to collect the read value.

Each access is a single chip-select frame in SPI mode 0, shifted MSB first. SCLK is the system clock divided down by the parameter `CLK_DIV`, where each SCLK half-period lasts `CLK_DIV` system cycles. `busy` marks the engine as occupied. `done` pulses once when chip select is released, and for a read `rd_data` holds the returned byte from that cycle. After each access the engine keeps chip select high for at least one full SCLK period before it accepts the next request.

Top module: `radio_spi_engine`

## Requirements
- R1: Short-space access (`req_long`=0): the first byte sent is {bit7=0, bits6:1=req_addr[5:0], bit0=req_write}. Address bits 9:6 are not used. The frame is 16 SCLK cycles.
- R2: Long-space access (`req_long`=1): the first byte is {bit7=1, bits6:0=req_addr[9:3]}. The second byte is {bits7:5=req_addr[2:0], bit4=req_write, bits3:0=0}. The frame is 24 SCLK cycles.
- R3: A read sends 0x00 as the byte after the header. The 8 MISO bits sampled during that byte, MSB first, appear on `rd_data` when `done` is high.
- R4: A write sends `req_wdata` as the byte right after the header, and the frame ends after that byte.
- R5: `spi_sclk` is low whenever `spi_cs_n` is high. `spi_cs_n` falls before the first SCLK rising edge and rises only after the last falling edge.
- R6: SPI mode 0: MISO is sampled on SCLK rising edges, and `spi_mosi` does not change while `spi_sclk` is high.
- R7: A request is taken when `req_valid` is high and `busy` is low. `busy` is high from the next cycle until after `done`. Requests made while `busy` is high have no effect.
- R8: `done` is a one-cycle pulse that occurs in the same cycle that `spi_cs_n` rises.
- R9: Between two transactions `spi_cs_n` stays high for at least 2*`CLK_DIV` system cycles.
- R10: During and right after reset: `spi_cs_n`=1, `spi_sclk`=0, `busy`=0, `done`=0.
- R11: A write leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_long | input | 1 | 1 = long (10-bit) space, 0 = short (6-bit) space |
| req_addr | input | 10 | Register address; short space uses bits 5:0 |
| req_wdata | input | 8 | Data byte for a write |
| busy | output | 1 | Engine occupied; requests ignored |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 8 | Byte returned by the last read |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the transceiver |
| spi_miso | input | 1 | Serial data from the transceiver |

## Verification
The properties assume that reset is held for at least one clock and that `req_valid` only matters while `busy` is low. They also assume the request fields are valid in the accept cycle, because the engine captures them there. The bench's slave model changes `spi_miso` only after SCLK rising edges, so the value the engine samples on a rising edge is always settled. Requests are normally raised only once `busy` has dropped. Some transactions deliberately raise `req_valid` with altered fields while `busy` is high, to show those requests are dropped. One sequence holds `req_valid` high across the end of a transaction to test the chip-select gap.

// File: rtl/radio_spi_pkg.sv
`timescale 1ns/1ps
package radio_spi_pkg;

    localparam int BYTE_W    = 8;
    localparam int SHORT_AW  = 6;
    localparam int LONG_AW   = 10;
    localparam int MAX_BYTES = 3;
    localparam int FRAME_W   = BYTE_W * MAX_BYTES;
    localparam int NBITS_W   = $clog2(FRAME_W + 1);
    localparam int SHORT_BITS = 2 * BYTE_W;
    localparam int LONG_BITS  = 3 * BYTE_W;

    typedef struct packed {
        logic                wr;
        logic                lng;
        logic [LONG_AW-1:0]  addr;
        logic [BYTE_W-1:0]   wdata;
    } acc_req_t;

    typedef struct packed {
        logic [FRAME_W-1:0]  bits;
        logic [NBITS_W-1:0]  nbits;
    } frame_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_XFER,
        ST_HOLD,
        ST_GAP
    } eng_state_e;

    // short space: marker 0 on top, direction flag at bit 0
    function automatic logic [BYTE_W-1:0] short_cmd(
        input logic [SHORT_AW-1:0] a, input logic wr);
        return {1'b0, a, wr};
    endfunction

    // long space, first header byte: marker 1 on top, upper address bits
    function automatic logic [BYTE_W-1:0] long_hdr_hi(input logic [LONG_AW-1:0] a);
        return {1'b1, a[LONG_AW-1:3]};
    endfunction

    // long space, second header byte: low address bits, direction flag at bit 4
    function automatic logic [BYTE_W-1:0] long_hdr_lo(
        input logic [LONG_AW-1:0] a, input logic wr);
        return {a[2:0], wr, 4'b0000};
    endfunction

endpackage

// File: rtl/radio_spi_cmd_enc.sv
`timescale 1ns/1ps
module radio_spi_cmd_enc
    import radio_spi_pkg::*;
(
    input  acc_req_t req,
    output frame_t   frame
);
    logic [BYTE_W-1:0] payload;

    always_comb begin
        payload = req.wr ? req.wdata : '0;
        if (req.lng) begin
            frame.bits  = {long_hdr_hi(req.addr), long_hdr_lo(req.addr, req.wr), payload};
            frame.nbits = NBITS_W'(LONG_BITS);
        end else begin
            frame.bits  = {short_cmd(req.addr[SHORT_AW-1:0], req.wr), payload, {BYTE_W{1'b0}}};
            frame.nbits = NBITS_W'(SHORT_BITS);
        end
    end
endmodule

// File: rtl/radio_spi_tick.sv
`timescale 1ns/1ps
module radio_spi_tick #(
    parameter int CLK_DIV = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en)  cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/radio_spi_shifter.sv
`timescale 1ns/1ps
module radio_spi_shifter
    import radio_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  frame_t            frame,
    input  logic              run,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              last_edge
);
    logic [FRAME_W-1:0] tx_q;
    logic [NBITS_W-1:0] bit_q;
    logic [NBITS_W-1:0] last_idx_q;
    logic [BYTE_W-1:0]  rx_q;
    logic               sclk_q;

    assign last_edge = run && tick && sclk_q && (bit_q == last_idx_q);
    assign sclk      = sclk_q;
    assign mosi      = tx_q[FRAME_W-1];
    assign rx_byte   = rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q       <= '0;
            bit_q      <= '0;
            last_idx_q <= '0;
            rx_q       <= '0;
            sclk_q     <= 1'b0;
        end else if (load) begin
            tx_q       <= frame.bits;
            bit_q      <= '0;
            last_idx_q <= frame.nbits - NBITS_W'(1);
            sclk_q     <= 1'b0;
        end else if (run && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_q   <= {rx_q[BYTE_W-2:0], miso};
            end else begin
                sclk_q <= 1'b0;
                if (bit_q != last_idx_q) begin
                    bit_q <= bit_q + NBITS_W'(1);
                    tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/radio_spi_ctrl.sv
`timescale 1ns/1ps
module radio_spi_ctrl
    import radio_spi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_wr,
    input  logic              tick,
    input  logic              last_edge,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              load,
    output logic              run,
    output logic              tick_en,
    output logic              busy,
    output logic              cs_n,
    output logic              done,
    output logic [BYTE_W-1:0] rd_data
);
    eng_state_e        state_q;
    logic              wr_q;
    logic              gap_q;
    logic              cs_n_q;
    logic              done_q;
    logic [BYTE_W-1:0] rd_q;

    assign busy    = (state_q != ST_IDLE);
    assign load    = req_valid && !busy;
    assign run     = (state_q == ST_XFER);
    assign tick_en = busy;
    assign cs_n    = cs_n_q;
    assign done    = done_q;
    assign rd_data = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            gap_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
            rd_q    <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (load) begin
                    state_q <= ST_SETUP;
                    cs_n_q  <= 1'b0;
                    wr_q    <= req_wr;
                end
                ST_SETUP: if (tick) state_q <= ST_XFER;
                ST_XFER:  if (last_edge) state_q <= ST_HOLD;
                ST_HOLD: if (tick) begin
                    cs_n_q  <= 1'b1;
                    done_q  <= 1'b1;
                    gap_q   <= 1'b0;
                    if (!wr_q) rd_q <= rx_byte;
                    state_q <= ST_GAP;
                end
                ST_GAP: if (tick) begin
                    if (gap_q) state_q <= ST_IDLE;
                    else       gap_q   <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/radio_spi_engine.sv
`timescale 1ns/1ps
module radio_spi_engine
    import radio_spi_pkg::*;
#(
    parameter int CLK_DIV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_long,
    input  logic [LONG_AW-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [BYTE_W-1:0] rd_data,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    acc_req_t          req;
    frame_t            frame;
    logic              load, run, tick_en, tick, last_edge;
    logic [BYTE_W-1:0] rx_byte;

    assign req = '{wr: req_write, lng: req_long, addr: req_addr, wdata: req_wdata};

    radio_spi_cmd_enc u_enc (
        .req   (req),
        .frame (frame)
    );

    radio_spi_tick #(.CLK_DIV(CLK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (tick_en),
        .tick (tick)
    );

    radio_spi_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .frame     (frame),
        .run       (run),
        .tick      (tick),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_byte   (rx_byte),
        .last_edge (last_edge)
    );

    radio_spi_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_wr    (req_write),
        .tick      (tick),
        .last_edge (last_edge),
        .rx_byte   (rx_byte),
        .load      (load),
        .run       (run),
        .tick_en   (tick_en),
        .busy      (busy),
        .cs_n      (spi_cs_n),
        .done      (done),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/radio_spi_engine_chk.sv
`timescale 1ns/1ps
module radio_spi_engine_chk #(
    parameter int CLK_DIV = 3
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi
);
    localparam int GW = $clog2(2 * CLK_DIV + 2) + 1;
    localparam logic [GW-1:0] MIN_GAP = GW'(2 * CLK_DIV);

    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst)                          gap_q <= '1;
        else if (!spi_cs_n)               gap_q <= '0;
        else if (gap_q != {GW{1'b1}})     gap_q <= gap_q + GW'(1);
    end

    // R5
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sclk);

    // R6
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_cs_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $rose(spi_cs_n));

    // R7
    busy_at_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R7
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> ($past(req_valid) && !$past(busy)));

    // R9
    cs_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs_n) |-> (gap_q >= MIN_GAP));

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (spi_cs_n && !spi_sclk && !busy && !done));
endmodule

bind radio_spi_engine radio_spi_engine_chk #(.CLK_DIV(CLK_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/sim_radio_spi_engine.sv
`timescale 1ns/1ps
module sim_radio_spi_engine;
    localparam int CLK_DIV = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic       req_long = 1'b0;
    logic [9:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       busy, done, spi_cs_n, spi_sclk, spi_mosi, spi_miso;
    logic [7:0] rd_data;

    always #4 clk = ~clk;

    radio_spi_engine #(.CLK_DIV(CLK_DIV)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0;
    int fails  = 0;

    // slave model: mode 0, captures MOSI on rising SCLK, advances MISO after it
    logic [23:0] slave_vec = '0;
    logic [23:0] cap_shift = '0;
    logic [23:0] cap_word  = '0;
    int          scnt  = 0;
    int          cap_n = 0;

    assign spi_miso = (scnt < 24) ? slave_vec[23 - scnt] : 1'b0;

    always @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            cap_word  = cap_shift;
            cap_n     = scnt;
            scnt      = 0;
            cap_shift = '0;
        end else begin
            cap_shift = {cap_shift[22:0], spi_mosi};
            scnt++;
        end
    end

    // pin monitor
    int   gap_run = 0, last_gap = 0, idle_sclk_err = 0, mosi_err = 0;
    logic prev_sclk = 1'b0, prev_mosi = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (spi_cs_n && spi_sclk) idle_sclk_err++;
            if (spi_sclk && prev_sclk && (spi_mosi !== prev_mosi)) mosi_err++;
            if (spi_cs_n) gap_run++;
            else begin
                if (gap_run > 0) last_gap = gap_run;
                gap_run = 0;
            end
        end
        prev_sclk = spi_sclk;
        prev_mosi = spi_mosi;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_frame(input bit wr, input bit lng,
                                              input logic [9:0] a, input logic [7:0] d);
        logic [7:0] pay;
        pay = wr ? d : 8'h00;
        if (lng) return {1'b1, a[9:3], a[2:0], wr, 4'b0000, pay};
        else     return {8'h00, 1'b0, a[5:0], wr, pay};
    endfunction

    task automatic wait_done(output bit seen);
        int t = 0;
        seen = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        seen = done;
    endtask

    task automatic run_acc(input bit wr, input bit lng, input logic [9:0] a,
                           input logic [7:0] d, input logic [7:0] reply, input bit poke);
        logic [7:0] prev_rd;
        bit         seen;
        int         nb;
        nb = lng ? 3 : 2;
        slave_vec = lng ? {~reply, ~reply, reply} : {~reply, reply, 8'h00};
        @(negedge clk);
        while (busy) @(negedge clk);
        prev_rd   = rd_data;
        req_write = wr; req_long = lng; req_addr = a; req_wdata = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 busy after accept", 32'(busy), 32'd1);
        if (poke) begin
            for (int i = 0; i < 4; i++) begin
                req_write = ~wr; req_long = ~lng; req_addr = ~a; req_wdata = ~d;
                req_valid = 1'b1;
                @(negedge clk);
            end
            req_valid = 1'b0;
        end
        wait_done(seen);
        check("R8 done seen", 32'(seen), 32'd1);
        check("R7 busy while done", 32'(busy), 32'd1);
        check("R8 cs rises with done", 32'(spi_cs_n), 32'd1);
        check(lng ? "R2 sclk count" : "R1 sclk count", 32'(cap_n), 32'(nb * 8));
        if (poke)
            check("R7 ignored request kept frame", 32'(cap_word), 32'(exp_frame(wr, lng, a, d)));
        else if (wr)
            check(lng ? "R4 R2 long write frame" : "R4 R1 short write frame",
                  32'(cap_word), 32'(exp_frame(wr, lng, a, d)));
        else
            check(lng ? "R3 R2 long read frame" : "R3 R1 short read frame",
                  32'(cap_word), 32'(exp_frame(wr, lng, a, d)));
        if (wr) check("R11 rd_data held on write", 32'(rd_data), 32'(prev_rd));
        else    check("R3 read data", 32'(rd_data), 32'(reply));
        @(negedge clk);
        check("R8 done one cycle", 32'(done), 32'd0);
        if (poke) begin
            while (busy) @(negedge clk);
            repeat (3) @(negedge clk);
            check("R7 no extra frame", 32'(spi_cs_n), 32'd1);
        end
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R10 state while in reset
        check("R10 cs_n in reset", 32'(spi_cs_n), 32'd1);
        check("R10 sclk in reset", 32'(spi_sclk), 32'd0);
        check("R10 busy in reset", 32'(busy), 32'd0);
        check("R10 done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 idle after reset", 32'({spi_cs_n, busy, done}), 32'b100);

        // directed corners
        run_acc(1'b0, 1'b0, 10'h3FF, 8'h00, 8'h5A, 1'b0); // short read, top address, upper bits ignored
        run_acc(1'b1, 1'b0, 10'h000, 8'hFF, 8'h11, 1'b0); // short write, address 0
        run_acc(1'b1, 1'b1, 10'h3FF, 8'hA5, 8'h22, 1'b0); // long write, top address
        run_acc(1'b0, 1'b1, 10'h000, 8'h00, 8'hC3, 1'b0); // long read, address 0
        run_acc(1'b0, 1'b1, 10'h207, 8'h00, 8'h81, 1'b1); // long read with ignored requests
        run_acc(1'b1, 1'b0, 10'h015, 8'h3C, 8'h00, 1'b1); // short write with ignored requests

        // R9 back-to-back: req_valid held across the end of a frame
        slave_vec = {8'hFF, 8'h00, 8'h00};
        req_write = 1'b0; req_long = 1'b0; req_addr = 10'h01; req_valid = 1'b1;
        wait_done(seen);
        @(negedge clk);
        while (spi_cs_n) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 cs high gap", 32'(last_gap >= 2 * CLK_DIV), 32'd1);
        wait_done(seen);
        check("R9 second frame done", 32'(seen), 32'd1);

        // random accesses
        for (int n = 0; n < 40; n++) begin
            run_acc(1'($urandom), 1'($urandom), 10'($urandom), 8'($urandom),
                    8'($urandom), ($urandom % 8) == 0);
        end

        @(negedge clk);
        while (busy) @(negedge clk);
        check("R5 sclk low while deselected", 32'(idle_sclk_err), 32'd0);
        check("R6 mosi stable while sclk high", 32'(mosi_err), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule